// File: doc/BRIEF.md
# Real-Time Clock Visible-Register Freeze and Set Controller

This block connects a byte-wide, memory-mapped bus to a BCD time-of-day counter that keeps running. Software never reads or writes the counters directly. It sees a separate bank of visible time registers. A control byte holds two request bits. The freeze bit stops the visible copy from following the counters, so a multi-byte time read cannot be torn across a second boundary. The set bit stops all copying, so software can write a new day, date and time in 24-hour BCD into the visible registers. Clearing the set bit loads those values into the counters in one transfer. After a freeze is released, the visible registers are refreshed together from one snapshot at the next one-second tick.

A single reference clock enable feeds a two-stage prescaler. The first stage produces a 512 Hz tick and the second produces the one-second tick. A frequency-test bit in the weekday register replaces bit 0 of every seconds read with a 512 Hz square wave.

The access controller is a four-state machine. The states are ST_RUN (the visible copy tracks the counters), ST_FREEZE (the visible copy holds), ST_PEND (the freeze was released and the controller waits for the next tick) and ST_HALT (set mode).

The transitions are:
- RUN→FREEZE: a control write with the freeze bit set.
- Any state→HALT: a control write with the set bit set.
- FREEZE→PEND: a control write with both bits clear.
- PEND→RUN: a one-second tick.
- PEND→FREEZE: a control write with the freeze bit set.
- HALT→RUN: transfer, on a control write with both bits clear.
- HALT→FREEZE: transfer, on a control write with the set bit clear and the freeze bit set.

Top module: `rtc_shadow_ctrl`

## Requirements
- R1: After reset the control byte reads 0x00 and the time reads 00:00:00. The weekday reads 0x01, the date 0x01, the month 0x01 and the year 0x00. The frequency-test bit is 0.
- R2: The control byte is at 0x1FF8. The time registers are at the following offsets from 0x1FF8: seconds +1, minutes +2, hours +3, weekday +4, date +5, month +6, year +7. In the control byte, bit 7 is the set bit and bit 6 is the freeze bit, and the other control bits read 0. Any address outside 0x1FF8 to 0x1FFF reads 0x00.
- R3: One second lasts REF_DIV*SUB_PER_SEC reference enables. Each second advances the time in BCD with these carries:
  - seconds and minutes roll from 59 to 00;
  - hours roll from 23 to 00;
  - weekday rolls from 7 to 1;
  - date rolls to 01 after the month's last day (30 for months 04, 06, 09 and 11; 28 for 02, or 29 when the year is divisible by 4; 31 otherwise);
  - month rolls from 12 to 01;
  - year rolls from 99 to 00.
- R4: While the freeze bit is set and the set bit is clear, the visible time registers do not change. The counters keep running.
- R5: Writing the control byte with both bits clear during a freeze leaves the old time visible until the next one-second tick. At that tick every field is loaded from the same snapshot of the running time.
- R6: A control write with the set bit set enters set mode. In set mode, time-register writes are stored and read back exactly as written, including invalid BCD. Outside set mode, writes to the time fields are ignored.
- R7: A control write with the set bit clear, made in set mode, loads the counters from the visible registers. It also restarts the prescaler, so the next tick comes one full second later. If the freeze bit is set in that same write, the controller enters freeze directly.
- R8: On a one-second tick that falls in the same cycle as a freeze or set request, the visible registers are not updated from the counters. On a tick that falls in the same cycle as a transfer, the transfer wins over the increment.
- R9: Bit 6 of the weekday register is the frequency-test bit and can be written in any mode. While it is 1, bit 0 of a seconds read shows a square wave that inverts on every 512 Hz tick, which is every REF_DIV reference enables. Clearing it restores normal seconds reads. The weekday field itself (bits 2:0) changes only in set mode.
- R10: A control write with both the set and freeze bits set enters set mode, and the control byte then reads 0x80.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ref_en | input | 1 | Reference clock enable that feeds the prescaler |
| bus_sel | input | 1 | Bus access strobe, one cycle per access |
| bus_we | input | 1 | 1 for a write, 0 for a read |
| bus_addr | input | 13 | Byte address |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, combinational from the address during a read; 0 otherwise |

## Verification
Two pairs of functions can fall in the same cycle. In the first, a one-second tick meets a freeze request: the tick must still advance the counters, but it must not update the visible copy. In the second, a tick meets a set-mode transfer: the transfer must win over the increment. The bench tracks the prescaler phase itself, counting reference enables since the last restart. It places the control write on exactly the reference enable that completes a second. It then judges the outcome from the visible seconds value and from the value seen one second after the release.

// File: rtl/rtc_shadow_pkg.sv
package rtc_shadow_pkg;

    localparam int NFIELD  = 7;
    localparam int F_SEC   = 0;
    localparam int F_MIN   = 1;
    localparam int F_HOUR  = 2;
    localparam int F_WDAY  = 3;
    localparam int F_DATE  = 4;
    localparam int F_MON   = 5;
    localparam int F_YEAR  = 6;

    localparam int CTRL_SET_BIT = 7;
    localparam int CTRL_FRZ_BIT = 6;
    localparam int FTEST_BIT    = 6;

    typedef logic [NFIELD-1:0][7:0] rtc_time_t;

    typedef enum logic [1:0] {
        ST_RUN    = 2'd0,
        ST_FREEZE = 2'd1,
        ST_PEND   = 2'd2,
        ST_HALT   = 2'd3
    } acc_state_e;

    function automatic logic [7:0] bcd_inc(input logic [7:0] v);
        logic [7:0] r;
        if (v[3:0] >= 4'd9) begin
            r = {v[7:4] + 4'd1, 4'd0};
        end else begin
            r = {v[7:4], v[3:0] + 4'd1};
        end
        return r;
    endfunction

    function automatic logic [7:0] bcd_month_len(input logic [7:0] mon,
                                                 input logic [7:0] yr);
        logic leap;
        logic [7:0] len;
        if (yr[4] == 1'b0) begin
            leap = (yr[3:0] == 4'd0) || (yr[3:0] == 4'd4) || (yr[3:0] == 4'd8);
        end else begin
            leap = (yr[3:0] == 4'd2) || (yr[3:0] == 4'd6);
        end
        unique case (mon)
            8'h02:                      len = leap ? 8'h29 : 8'h28;
            8'h04, 8'h06, 8'h09, 8'h11: len = 8'h30;
            default:                    len = 8'h31;
        endcase
        return len;
    endfunction

endpackage

// File: rtl/rtc_tick_gen.sv
module rtc_tick_gen #(
    parameter int REF_DIV     = 64,
    parameter int SUB_PER_SEC = 512
) (
    input  logic clk,
    input  logic rst_n,
    input  logic ref_en,
    input  logic restart,
    output logic tick_sub,
    output logic tick_sec,
    output logic sq_wave
);
    localparam int RW = (REF_DIV > 1) ? $clog2(REF_DIV) : 1;
    localparam int SW = (SUB_PER_SEC > 1) ? $clog2(SUB_PER_SEC) : 1;
    localparam logic [RW-1:0] REF_LAST = RW'(REF_DIV - 1);
    localparam logic [SW-1:0] SUB_LAST = SW'(SUB_PER_SEC - 1);

    logic [RW-1:0] ref_cnt;
    logic [SW-1:0] sub_cnt;

    assign tick_sub = ref_en && !restart && (ref_cnt == REF_LAST);
    assign tick_sec = tick_sub && (sub_cnt == SUB_LAST);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ref_cnt <= '0;
            sub_cnt <= '0;
            sq_wave <= 1'b0;
        end else if (restart) begin
            ref_cnt <= '0;
            sub_cnt <= '0;
        end else if (ref_en) begin
            ref_cnt <= tick_sub ? '0 : ref_cnt + RW'(1);
            if (tick_sub) begin
                sub_cnt <= tick_sec ? '0 : sub_cnt + SW'(1);
                sq_wave <= ~sq_wave;
            end
        end
    end

endmodule

// File: rtl/rtc_bcd_counter.sv
module rtc_bcd_counter
    import rtc_shadow_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      tick,
    input  logic      load,
    input  rtc_time_t load_val,
    output rtc_time_t cnt,
    output rtc_time_t nxt
);
    logic sec_wrap, min_wrap, hour_wrap, day_roll, mon_roll, mon_last;

    always_comb begin
        sec_wrap  = (cnt[F_SEC]  == 8'h59);
        min_wrap  = (cnt[F_MIN]  == 8'h59);
        hour_wrap = (cnt[F_HOUR] == 8'h23);
        day_roll  = sec_wrap && min_wrap && hour_wrap;
        mon_last  = (cnt[F_DATE] == bcd_month_len(cnt[F_MON], cnt[F_YEAR]));
        mon_roll  = day_roll && mon_last;

        nxt = cnt;
        nxt[F_SEC] = sec_wrap ? 8'h00 : bcd_inc(cnt[F_SEC]);
        if (sec_wrap) begin
            nxt[F_MIN] = min_wrap ? 8'h00 : bcd_inc(cnt[F_MIN]);
        end
        if (sec_wrap && min_wrap) begin
            nxt[F_HOUR] = hour_wrap ? 8'h00 : bcd_inc(cnt[F_HOUR]);
        end
        if (day_roll) begin
            nxt[F_WDAY] = (cnt[F_WDAY] == 8'h07) ? 8'h01 : bcd_inc(cnt[F_WDAY]);
            nxt[F_DATE] = mon_last ? 8'h01 : bcd_inc(cnt[F_DATE]);
        end
        if (mon_roll) begin
            nxt[F_MON] = (cnt[F_MON] == 8'h12) ? 8'h01 : bcd_inc(cnt[F_MON]);
            if (cnt[F_MON] == 8'h12) begin
                nxt[F_YEAR] = (cnt[F_YEAR] == 8'h99) ? 8'h00 : bcd_inc(cnt[F_YEAR]);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt         <= '0;
            cnt[F_WDAY] <= 8'h01;
            cnt[F_DATE] <= 8'h01;
            cnt[F_MON]  <= 8'h01;
        end else if (load) begin
            cnt <= load_val;
        end else if (tick) begin
            cnt <= nxt;
        end
    end

endmodule

// File: rtl/rtc_access_fsm.sv
module rtc_access_fsm
    import rtc_shadow_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       ctrl_wr,
    input  logic       set_req,
    input  logic       frz_req,
    input  logic       tick_sec,
    output acc_state_e st,
    output logic       load_cnt,
    output logic       take_snap
);
    acc_state_e st_nxt;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st <= ST_RUN;
        end else begin
            st <= st_nxt;
        end
    end

    always_comb begin
        st_nxt = st;
        unique case (st)
            ST_RUN: begin
                if (ctrl_wr && set_req)      st_nxt = ST_HALT;
                else if (ctrl_wr && frz_req) st_nxt = ST_FREEZE;
            end
            ST_FREEZE: begin
                if (ctrl_wr && set_req)      st_nxt = ST_HALT;
                else if (ctrl_wr && frz_req) st_nxt = ST_FREEZE;
                else if (ctrl_wr)            st_nxt = ST_PEND;
            end
            ST_PEND: begin
                if (ctrl_wr && set_req)      st_nxt = ST_HALT;
                else if (ctrl_wr && frz_req) st_nxt = ST_FREEZE;
                else if (tick_sec)           st_nxt = ST_RUN;
            end
            ST_HALT: begin
                if (ctrl_wr && !set_req) begin
                    st_nxt = frz_req ? ST_FREEZE : ST_RUN;
                end
            end
            default: st_nxt = ST_RUN;
        endcase
    end

    always_comb begin
        load_cnt  = (st == ST_HALT) && ctrl_wr && !set_req;
        take_snap = tick_sec && ((st == ST_RUN) || (st == ST_PEND))
                    && !(ctrl_wr && (set_req || frz_req));
    end

endmodule

// File: rtl/rtc_shadow_ctrl.sv
module rtc_shadow_ctrl
    import rtc_shadow_pkg::*;
#(
    parameter int              ADDR_W      = 13,
    parameter logic [12:0]     REG_BASE    = 13'h1FF8,
    parameter int              REF_DIV     = 64,
    parameter int              SUB_PER_SEC = 512
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ref_en,
    input  logic              bus_sel,
    input  logic              bus_we,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [7:0]        bus_wdata,
    output logic [7:0]        bus_rdata
);
    localparam int IDX_W = 3;
    localparam logic [ADDR_W-1:0] BASE_A = ADDR_W'(REG_BASE);

    logic             hit;
    logic [IDX_W-1:0] idx;
    logic             wr_hit, ctrl_wr, set_req, frz_req;
    logic             tick_sub, tick_sec, sq_wave;
    logic             load_cnt, take_snap, ftest;
    acc_state_e       st;
    rtc_time_t        vis, cnt, nxt;

    assign hit     = bus_sel && (bus_addr[ADDR_W-1:IDX_W] == BASE_A[ADDR_W-1:IDX_W]);
    assign idx     = bus_addr[IDX_W-1:0];
    assign wr_hit  = hit && bus_we;
    assign ctrl_wr = wr_hit && (idx == '0);
    assign set_req = bus_wdata[CTRL_SET_BIT];
    assign frz_req = bus_wdata[CTRL_FRZ_BIT];

    rtc_tick_gen #(
        .REF_DIV     (REF_DIV),
        .SUB_PER_SEC (SUB_PER_SEC)
    ) u_tick (
        .clk      (clk),
        .rst_n    (rst_n),
        .ref_en   (ref_en),
        .restart  (load_cnt),
        .tick_sub (tick_sub),
        .tick_sec (tick_sec),
        .sq_wave  (sq_wave)
    );

    rtc_bcd_counter u_cnt (
        .clk      (clk),
        .rst_n    (rst_n),
        .tick     (tick_sec),
        .load     (load_cnt),
        .load_val (vis),
        .cnt      (cnt),
        .nxt      (nxt)
    );

    rtc_access_fsm u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .ctrl_wr   (ctrl_wr),
        .set_req   (set_req),
        .frz_req   (frz_req),
        .tick_sec  (tick_sec),
        .st        (st),
        .load_cnt  (load_cnt),
        .take_snap (take_snap)
    );

    // Visible register bank: one byte per field, offset = field index + 1.
    for (genvar i = 0; i < NFIELD; i++) begin : g_vis
        localparam logic [7:0] RST_V =
            ((i == F_WDAY) || (i == F_DATE) || (i == F_MON)) ? 8'h01 : 8'h00;
        localparam logic [7:0] WMASK = (i == F_WDAY) ? ~(8'h01 << FTEST_BIT) : 8'hFF;
        logic field_wr;
        assign field_wr = wr_hit && (st == ST_HALT) && (idx == IDX_W'(i + 1));
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                vis[i] <= RST_V;
            end else if (take_snap) begin
                vis[i] <= nxt[i];
            end else if (field_wr) begin
                vis[i] <= bus_wdata & WMASK;
            end
        end
    end

    // Frequency-test bit: writable in every state.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ftest <= 1'b0;
        end else if (wr_hit && (idx == IDX_W'(F_WDAY + 1))) begin
            ftest <= bus_wdata[FTEST_BIT];
        end
    end

    always_comb begin
        bus_rdata = 8'h00;
        if (hit && !bus_we) begin
            unique case (idx)
                3'd0: begin
                    bus_rdata[CTRL_SET_BIT] = (st == ST_HALT);
                    bus_rdata[CTRL_FRZ_BIT] = (st == ST_FREEZE);
                end
                3'd1: bus_rdata = ftest ? {vis[F_SEC][7:1], sq_wave} : vis[F_SEC];
                3'd2: bus_rdata = vis[F_MIN];
                3'd3: bus_rdata = vis[F_HOUR];
                3'd4: begin
                    bus_rdata = vis[F_WDAY];
                    bus_rdata[FTEST_BIT] = ftest;
                end
                3'd5: bus_rdata = vis[F_DATE];
                3'd6: bus_rdata = vis[F_MON];
                3'd7: bus_rdata = vis[F_YEAR];
                default: bus_rdata = 8'h00;
            endcase
        end
    end

endmodule

// File: rtl/rtc_shadow_ctrl_chk.sv
module rtc_shadow_ctrl_chk
    import rtc_shadow_pkg::*;
(
    input logic       clk,
    input logic       rst_n,
    input acc_state_e st,
    input rtc_time_t  vis,
    input rtc_time_t  cnt,
    input logic       tick_sec,
    input logic       tick_sub,
    input logic       sq_wave,
    input logic       load_cnt,
    input logic       ctrl_wr,
    input logic       set_req,
    input logic       frz_req
);
    a_r4_freeze_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_FREEZE) |=> (vis == $past(vis)));

    a_r5_refresh_coherent: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_PEND && tick_sec && !ctrl_wr) |=> (st == ST_RUN && vis == cnt));

    a_r7_load_copies: assert property (@(posedge clk) disable iff (!rst_n)
        load_cnt |=> (cnt == $past(vis)));

    a_r3_run_tracks: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_RUN) |-> (vis == cnt));

    a_r8_freeze_beats_tick: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_RUN && tick_sec && ctrl_wr && frz_req && !set_req)
        |=> (st == ST_FREEZE && vis == $past(vis)));

    a_r9_square_flips: assert property (@(posedge clk) disable iff (!rst_n)
        tick_sub |=> (sq_wave != $past(sq_wave)));

endmodule

bind rtc_shadow_ctrl rtc_shadow_ctrl_chk u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .st       (st),
    .vis      (vis),
    .cnt      (cnt),
    .tick_sec (tick_sec),
    .tick_sub (tick_sub),
    .sq_wave  (sq_wave),
    .load_cnt (load_cnt),
    .ctrl_wr  (ctrl_wr),
    .set_req  (set_req),
    .frz_req  (frz_req)
);

// File: tb/rtc_shadow_ctrl_tb.sv
`timescale 1ns/1ps
module rtc_shadow_ctrl_tb;
    localparam int REF_DIV = 2;
    localparam int SUBS    = 4;
    localparam int PER     = REF_DIV * SUBS;
    localparam logic [12:0] B = 13'h1FF8;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic ref_en = 1'b0;
    logic bus_sel = 1'b0;
    logic bus_we = 1'b0;
    logic [12:0] bus_addr = '0;
    logic [7:0] bus_wdata = '0;
    logic [7:0] bus_rdata;

    int n_tests = 0;
    int n_fail = 0;
    logic [7:0] rv;

    always #10 clk = ~clk;

    rtc_shadow_ctrl #(.REF_DIV(REF_DIV), .SUB_PER_SEC(SUBS)) u_dut (
        .clk(clk), .rst_n(rst_n), .ref_en(ref_en), .bus_sel(bus_sel),
        .bus_we(bus_we), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata)
    );

    function automatic logic [7:0] to_bcd(input int n);
        return 8'((n / 10) * 16 + (n % 10));
    endfunction

    function automatic int days_in(input int m, input int y);
        if (m == 2) return (y % 4 == 0) ? 29 : 28;
        if (m == 4 || m == 6 || m == 9 || m == 11) return 30;
        return 31;
    endfunction

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: got 0x%02h expected 0x%02h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [12:0] a, input logic [7:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_sel = 1'b0; bus_we = 1'b0;
    endtask

    task automatic wr_with_ref(input logic [12:0] a, input logic [7:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d; ref_en = 1'b1;
        @(negedge clk);
        bus_sel = 1'b0; bus_we = 1'b0; ref_en = 1'b0;
    endtask

    task automatic rd(input logic [12:0] a, output logic [7:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_we = 1'b0; bus_addr = a;
        #2 d = bus_rdata;
        bus_sel = 1'b0;
    endtask

    task automatic pulse(input int n);
        for (int k = 0; k < n; k++) begin
            @(negedge clk); ref_en = 1'b1;
            @(negedge clk); ref_en = 1'b0;
        end
    endtask

    task automatic set_time(input logic [7:0] h, input logic [7:0] m, input logic [7:0] s,
                            input logic [7:0] wd, input logic [7:0] dt,
                            input logic [7:0] mo, input logic [7:0] yr);
        wr(B, 8'h80);
        wr(B + 1, s); wr(B + 2, m); wr(B + 3, h); wr(B + 4, wd);
        wr(B + 5, dt); wr(B + 6, mo); wr(B + 7, yr);
        wr(B, 8'h00);
    endtask

    initial begin
        #(200000 * 20);
        n_fail++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        rd(B, rv);     check("R1 ctrl", rv, 8'h00);
        rd(B + 1, rv); check("R1 sec", rv, 8'h00);
        rd(B + 3, rv); check("R1 hour", rv, 8'h00);
        rd(B + 4, rv); check("R1 wday", rv, 8'h01);
        rd(B + 5, rv); check("R1 date", rv, 8'h01);
        rd(B + 6, rv); check("R1 month", rv, 8'h01);
        rd(B + 7, rv); check("R1 year", rv, 8'h00);

        // R2 unmapped addresses read zero
        rd(13'h0000, rv); check("R2 unmapped low", rv, 8'h00);
        rd(13'h1FF0, rv); check("R2 unmapped near", rv, 8'h00);

        // R3 plain counting
        pulse(3 * PER);
        rd(B + 1, rv); check("R3 three seconds", rv, 8'h03);

        // R6 set mode stores invalid BCD as written
        wr(B, 8'h80);
        rd(B, rv); check("R6 ctrl set", rv, 8'h80);
        wr(B + 2, 8'h7F);
        rd(B + 2, rv); check("R6 raw write", rv, 8'h7F);
        wr(B, 8'h00);

        // R3 sweep of month ends over a non-leap and a leap year, plus century wrap
        for (int yi = 0; yi < 3; yi++) begin
            for (int m = 1; m <= 12; m++) begin
                int y;
                int d;
                y = (yi == 0) ? 23 : (yi == 1) ? 24 : 99;
                if (yi == 2 && m != 12) continue;
                d = days_in(m, y);
                set_time(8'h23, 8'h59, 8'h59, 8'h07, to_bcd(d), to_bcd(m), to_bcd(y));
                pulse(PER);
                rd(B + 1, rv); check("R3 sec wrap", rv, 8'h00);
                rd(B + 2, rv); check("R3 min wrap", rv, 8'h00);
                rd(B + 3, rv); check("R3 hour wrap", rv, 8'h00);
                rd(B + 4, rv); check("R3 wday wrap", rv, 8'h01);
                rd(B + 5, rv); check("R3 date wrap", rv, 8'h01);
                rd(B + 6, rv); check("R3 month", rv, to_bcd(m == 12 ? 1 : m + 1));
                rd(B + 7, rv); check("R3 year", rv, to_bcd(m == 12 ? (y + 1) % 100 : y));
            end
        end
        // R3 Feb 28 in leap year does not roll
        set_time(8'h23, 8'h59, 8'h59, 8'h02, 8'h28, 8'h02, 8'h24);
        pulse(PER);
        rd(B + 5, rv); check("R3 leap feb 29", rv, 8'h29);

        // R4 / R5 freeze and deferred refresh
        set_time(8'h10, 8'h20, 8'h30, 8'h03, 8'h15, 8'h06, 8'h24);
        rd(B + 3, rv); check("R7 transfer visible", rv, 8'h10);
        wr(B, 8'h40);
        rd(B, rv); check("R4 ctrl freeze", rv, 8'h40);
        pulse(2 * PER);
        rd(B + 1, rv); check("R4 frozen sec", rv, 8'h30);
        wr(B, 8'h00);
        rd(B, rv); check("R5 ctrl pend", rv, 8'h00);
        rd(B + 1, rv); check("R5 refresh deferred", rv, 8'h30);
        pulse(PER);
        rd(B + 1, rv); check("R5 refreshed sec", rv, 8'h33);
        rd(B + 2, rv); check("R5 refreshed min", rv, 8'h20);

        // R8 freeze request on the tick edge
        pulse(PER - 1);
        wr_with_ref(B, 8'h40);
        rd(B + 1, rv); check("R8 freeze beats tick", rv, 8'h33);
        wr(B, 8'h00);
        pulse(PER);
        rd(B + 1, rv); check("R8 counters kept running", rv, 8'h35);

        // R8 transfer on the tick edge
        wr(B, 8'h80);
        wr(B + 1, 8'h10);
        pulse(PER - 1);
        wr_with_ref(B, 8'h00);
        rd(B + 1, rv); check("R8 load beats tick", rv, 8'h10);
        pulse(PER - 1);
        rd(B + 1, rv); check("R7 no early tick", rv, 8'h10);
        pulse(1);
        rd(B + 1, rv); check("R7 full second after load", rv, 8'h11);

        // R6 writes outside set mode ignored
        wr(B + 1, 8'h45);
        rd(B + 1, rv); check("R6 ignored write", rv, 8'h11);

        // R10 both bits -> set mode; R7 transfer straight into freeze
        wr(B, 8'hC0);
        rd(B, rv); check("R10 ctrl both", rv, 8'h80);
        wr(B + 1, 8'h20);
        wr(B, 8'h40);
        rd(B, rv); check("R7 ctrl freeze after load", rv, 8'h40);
        pulse(PER);
        rd(B + 1, rv); check("R7 frozen after load", rv, 8'h20);
        wr(B, 8'h00);
        pulse(PER);
        rd(B + 1, rv); check("R7 counters loaded", rv, 8'h22);

        // R9 frequency test
        wr(B + 4, 8'h45);
        rd(B + 4, rv); check("R9 ft set, wday kept", rv, 8'h43);
        for (int k = 0; k < 6; k++) begin
            logic [7:0] a;
            logic [7:0] b;
            rd(B + 1, a);
            pulse(REF_DIV);
            rd(B + 1, b);
            check("R9 bit0 flips", {7'd0, b[0]}, {7'd0, ~a[0]});
        end
        wr(B + 4, 8'h00);
        rd(B + 4, rv); check("R9 ft clear", rv, 8'h03);
        rd(B + 1, rv); check("R9 normal seconds", rv, 8'h23);

        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule